// File: doc/BRIEF.md
# Clock Presence Monitor

This block watches a monitored clock from an independent reference-clock domain and flags it when it is missing or running too slowly. Each rising edge of the monitored clock flips a toggle flop in that clock's own domain. The toggle is carried into the reference domain through a two-flop synchroniser. There, changes of the toggle are counted over fixed intervals of reference cycles. If an interval ends with fewer edges than a threshold, the monitor declares an error. The monitor's error pulls a shared active-low alarm line low. That line is the AND of the watchdog's active-low output and the monitor's own output.

The monitor comes out of reset already reporting an error. The error stays asserted until an interval passes with enough edges, and is then released after a fixed stretch of reference cycles. An oscillator that never starts therefore keeps the alarm low for as long as it stays silent. A configuration bit supplied by the watchdog can switch the monitor off; while it is off, the alarm follows the watchdog alone. With the defaults, an interval is 50000 reference cycles, which is 1 ms at 50 MHz, and the threshold is 2 edges per interval. A 2 kHz limit sits well clear of both the rate that must always pass (10 kHz) and the rate that must always fail (10 Hz).

Top module: `clk_presence_mon`

## Requirements
- R1: While rst_ni is low, mon_fail_o is 0 and alarm_n_o equals wd_n_i. After the first reference edge with rst_ni high, the monitor is active and reports an error (mon_fail_o = 1) until the clock is proven good.
- R2: A monitored clock that never toggles keeps mon_fail_o at 1 and alarm_n_o at 0 continuously.
- R3: An interval is INTERVAL_CYCLES reference cycles long. It is good when at least MIN_EDGES monitored rising edges are counted in it, and bad otherwise. The rule holds for monitored clocks slower than half the reference rate, and a good rate held steady never raises an error.
- R4: Once the monitor is in its good state, a bad interval raises mon_fail_o one reference cycle after the interval closes. Interval ends fall on reference edges numbered k*INTERVAL_CYCLES after reset, so the fall appears after edge k*INTERVAL_CYCLES+1.
- R5: After the first good interval that follows an error, mon_fail_o is released exactly HOLD_CYCLES+1 reference edges after the interval-end edge. The parameter is meant to be set between 16 and 32 and defaults to 24.
- R6: While en_i is 0, mon_fail_o is 0 and alarm_n_o equals wd_n_i. When en_i returns to 1, the monitor restarts in the error state and needs a good interval plus the stretch to release.
- R7: alarm_n_o is 0 whenever wd_n_i is 0 or mon_fail_o is 1, and is 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset, applied to both domains |
| mon_clk_i | input | 1 | Monitored clock |
| en_i | input | 1 | Monitor enable from the watchdog configuration |
| wd_n_i | input | 1 | Active-low watchdog output to be merged |
| mon_fail_o | output | 1 | Monitor error, active high |
| alarm_n_o | output | 1 | Shared active-low alarm |

## Verification
All timing is counted in reference edges since reset. An interval closes at edge k*INTERVAL_CYCLES and its result is registered one edge later. A fall of the alarm caused by a bad interval is therefore due after edge k*INTERVAL_CYCLES+1. A release is due HOLD_CYCLES edges after that, at edge k*INTERVAL_CYCLES+HOLD_CYCLES+1. The bench keeps its own count of reference edges and samples the outputs at the falling edge. Each observed transition is checked against its expected position modulo the interval. The results of en_i and wd_n_i are combinational and are checked at the next falling edge.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;
  typedef enum logic [1:0] {
    ST_FAIL = 2'd0,
    ST_HOLD = 2'd1,
    ST_OK   = 2'd2
  } mon_state_e;
endpackage

// File: rtl/clkmon_edge_sync.sv
module clkmon_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mon_clk_i,
  output logic edge_o
);
  logic tog_q;
  logic [SYNC_STAGES:0] sh_q;

  // toggle in monitored domain, one flip per rising edge
  always_ff @(posedge mon_clk_i or negedge rst_ni) begin
    if (!rst_ni) tog_q <= 1'b0;
    else         tog_q <= ~tog_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SYNC_STAGES-1:0], tog_q};
  end

  assign edge_o = sh_q[SYNC_STAGES] ^ sh_q[SYNC_STAGES-1];
endmodule

// File: rtl/clkmon_rate_cnt.sv
module clkmon_rate_cnt #(
  parameter int INTERVAL_CYCLES = 50000,
  parameter int MIN_EDGES       = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic edge_i,
  output logic done_o,
  output logic ok_o
);
  localparam int TW = $clog2(INTERVAL_CYCLES);
  localparam int CW = $clog2(MIN_EDGES + 1);

  logic [TW-1:0] tick_q;
  logic [CW-1:0] cnt_q;
  logic [CW:0]   sum;
  logic          wrap, done_q, ok_q;

  assign wrap = (tick_q == TW'(INTERVAL_CYCLES - 1));
  assign sum  = {1'b0, cnt_q} + (CW+1)'(edge_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
      ok_q   <= 1'b0;
    end else if (wrap) begin
      tick_q <= '0;
      cnt_q  <= '0;
      done_q <= 1'b1;
      ok_q   <= (sum >= (CW+1)'(MIN_EDGES));
    end else begin
      tick_q <= tick_q + 1'b1;
      done_q <= 1'b0;
      if (edge_i && cnt_q != CW'(MIN_EDGES)) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done_o = done_q;
  assign ok_o   = ok_q;

  // R3
  done_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> tick_q == '0);
  // R3
  cnt_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(MIN_EDGES));
endmodule

// File: rtl/clkmon_alarm_fsm.sv
module clkmon_alarm_fsm
  import clkmon_pkg::*;
#(
  parameter int HOLD_CYCLES = 24
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic done_i,
  input  logic ok_i,
  output logic fail_o
);
  localparam int HW = $clog2(HOLD_CYCLES);

  mon_state_e    state_q, state_d;
  logic [HW-1:0] hold_q, hold_d;

  always_comb begin
    state_d = state_q;
    hold_d  = hold_q;
    if (!en_i) begin
      state_d = ST_FAIL;
      hold_d  = '0;
    end else begin
      unique case (state_q)
        ST_FAIL: if (done_i && ok_i) begin
          state_d = ST_HOLD;
          hold_d  = '0;
        end
        ST_HOLD: begin
          if (done_i && !ok_i)                  state_d = ST_FAIL;
          else if (hold_q == HW'(HOLD_CYCLES-1)) state_d = ST_OK;
          else                                  hold_d  = hold_q + 1'b1;
        end
        ST_OK:   if (done_i && !ok_i) state_d = ST_FAIL;
        default: state_d = ST_FAIL;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_FAIL;
      hold_q  <= '0;
    end else begin
      state_q <= state_d;
      hold_q  <= hold_d;
    end
  end

  assign fail_o = (state_q != ST_OK);

  // R4
  bad_to_fail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && done_i && !ok_i) |=> state_q == ST_FAIL);
  // R5
  hold_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OK && $past(state_q) == ST_HOLD) |-> $past(hold_q) == HW'(HOLD_CYCLES-1));
  // R6
  dis_fail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> state_q == ST_FAIL);
endmodule

// File: rtl/clk_presence_mon.sv
module clk_presence_mon #(
  parameter int INTERVAL_CYCLES = 50000,
  parameter int MIN_EDGES       = 2,
  parameter int HOLD_CYCLES     = 24,
  parameter int SYNC_STAGES     = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mon_clk_i,
  input  logic en_i,
  input  logic wd_n_i,
  output logic mon_fail_o,
  output logic alarm_n_o
);
  logic edge_s, done_s, ok_s, fail_s, act_q;

  clkmon_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .mon_clk_i(mon_clk_i), .edge_o(edge_s)
  );

  clkmon_rate_cnt #(.INTERVAL_CYCLES(INTERVAL_CYCLES), .MIN_EDGES(MIN_EDGES)) u_rate (
    .clk_i(clk_i), .rst_ni(rst_ni), .edge_i(edge_s), .done_o(done_s), .ok_o(ok_s)
  );

  clkmon_alarm_fsm #(.HOLD_CYCLES(HOLD_CYCLES)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .done_i(done_s), .ok_i(ok_s),
    .fail_o(fail_s)
  );

  // monitor inactive while in reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= 1'b0;
    else         act_q <= 1'b1;
  end

  assign mon_fail_o = act_q & en_i & fail_s;
  assign alarm_n_o  = wd_n_i & ~mon_fail_o;

  // R1
  active_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!act_q && en_i) |=> mon_fail_o);
endmodule

// File: tb/clk_presence_mon_tb_top.sv
`timescale 1ns/1ps
module clk_presence_mon_tb_top;
  localparam int IV = 64;
  localparam int ME = 4;
  localparam int HC = 24;

  logic clk = 1'b0, rst_n = 1'b0, mon_clk = 1'b0, en = 1'b1, wd_n = 1'b1;
  logic mon_fail, alarm_n;
  int   mon_per = 0;
  int   ecnt = 0;
  int   errs = 0, checks = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  initial begin
    #3;
    forever begin
      if (mon_per == 0) begin mon_clk = 1'b0; #20; end
      else begin #(mon_per * 10) mon_clk = ~mon_clk; end
    end
  end

  always @(posedge clk) if (rst_n) ecnt <= ecnt + 1;

  clk_presence_mon #(.INTERVAL_CYCLES(IV), .MIN_EDGES(ME), .HOLD_CYCLES(HC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mon_clk_i(mon_clk), .en_i(en), .wd_n_i(wd_n),
    .mon_fail_o(mon_fail), .alarm_n_o(alarm_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // wait for alarm_n to reach lvl; returns edge count or -1
  task automatic wait_alarm(input logic lvl, input int tmo, output int at);
    at = -1;
    for (int i = 0; i < tmo; i++) begin
      @(negedge clk);
      if (alarm_n === lvl) begin at = ecnt; break; end
    end
  endtask

  // alarm must hold lvl for n cycles
  task automatic hold_check(input logic lvl, input int n, input string req);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (alarm_n !== lvl) bad++;
    end
    chk(bad == 0, req, bad, 0);
  endtask

  initial begin
    #400000;
    errs++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int at;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(alarm_n === 1'b1 && mon_fail === 1'b0, "R1 in reset", alarm_n, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(alarm_n === 1'b0 && mon_fail === 1'b1, "R1 first edge", alarm_n, 0);
    // R2 stopped clock
    hold_check(1'b0, 4 * IV, "R2 no clock");
    chk(mon_fail === 1'b1, "R2 fail flag", mon_fail, 1);
    // R5 release after good interval
    mon_per = 8;
    wait_alarm(1'b1, 4 * IV, at);
    chk(at >= 0 && at % IV == HC + 1, "R5 release edge", at % IV, HC + 1);
    // R3 fast clock stays good
    hold_check(1'b1, 3 * IV, "R3 fast good");
    // R3 exactly at threshold
    mon_per = 16;
    hold_check(1'b1, 4 * IV, "R3 at threshold");
    // R4 below threshold
    mon_per = 22;
    wait_alarm(1'b0, 3 * IV, at);
    chk(at >= 0 && at % IV == 1, "R4 slow fall edge", at % IV, 1);
    hold_check(1'b0, 3 * IV, "R3 slow stays bad");
    // recover then stop
    mon_per = 8;
    wait_alarm(1'b1, 4 * IV, at);
    chk(at >= 0 && at % IV == HC + 1, "R5 second release", at % IV, HC + 1);
    mon_per = 0;
    wait_alarm(1'b0, 3 * IV, at);
    chk(at >= 0 && at % IV == 1, "R4 stop fall edge", at % IV, 1);
    // R7 watchdog merge
    mon_per = 8;
    wait_alarm(1'b1, 4 * IV, at);
    chk(at >= 0, "R7 monitor good", at, 1);
    wd_n = 1'b0;
    @(negedge clk);
    chk(alarm_n === 1'b0 && mon_fail === 1'b0, "R7 wd low monitor ok", alarm_n, 0);
    wd_n = 1'b1;
    @(negedge clk);
    chk(alarm_n === 1'b1, "R7 both inactive", alarm_n, 1);
    // R6 disable
    mon_per = 0;
    en = 1'b0;
    @(negedge clk);
    chk(alarm_n === 1'b1 && mon_fail === 1'b0, "R6 disabled", alarm_n, 1);
    hold_check(1'b1, 3 * IV, "R6 disabled no clock");
    wd_n = 1'b0;
    @(negedge clk);
    chk(alarm_n === 1'b0, "R6 wd passes when disabled", alarm_n, 0);
    wd_n = 1'b1;
    en = 1'b1;
    @(negedge clk);
    chk(alarm_n === 1'b0 && mon_fail === 1'b1, "R6 re-enable error", alarm_n, 0);
    mon_per = 8;
    wait_alarm(1'b1, 4 * IV, at);
    chk(at >= 0 && at % IV == HC + 1, "R6 release after re-enable", at % IV, HC + 1);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule